// File: doc/BRIEF.md
# Completion Timeout and Error Reporter

This block sits on the application side of a PCI Express endpoint. It tracks the non-posted requests the application has issued. It reports completion-related problems to the transaction layer as one-cycle pulses on a 7-bit error vector. Each outstanding request occupies a table slot selected by its tag. The slot is released when a completion with that tag returns. If no completion arrives within a programmable number of clocks, the slot times out. The timeout is reported on one of two bits, depending on whether the request was marked as recoverable. A completion whose tag has no live slot is flagged as unexpected.

The block also takes reject decisions for incoming requests, either completer abort or unsupported request. A rejected posted request is reported at once. A rejected non-posted request first raises a status-completion request toward the transmit side and holds it until acknowledged. Only in the cycle after the acknowledge is the error bit pulsed. While that completion is pending, new rejects are refused.

Top module: `cpl_err_tracker`

## Requirements
- R1: After reset, err_pulse is all zero, stc_req is low and rej_ready is high.
- R2: A request issued on tag t with np_issue[t] high at clock edge E, and not completed, expires at edge E+TIMEOUT_CYC. It is reported in the cycle after edge E+TIMEOUT_CYC+1, provided no other timeout is queued ahead of it. The report is err_pulse[0] if np_issue_corr[t] was 1 at issue, and err_pulse[1] otherwise.
- R3: A completion (cpl_in_valid) whose tag names a live entry frees that entry without any pulse, and that request never times out. This holds even on the edge where the entry would have expired.
- R4: A completion whose tag names no live entry gives err_pulse[3] in the cycle after it is sampled.
- R5: An accepted posted reject (rej_posted=1) gives err_pulse[2] for completer abort (rej_unsup=0) or err_pulse[4] for unsupported request (rej_unsup=1) in the next cycle, and raises no stc_req.
- R6: An accepted non-posted reject raises stc_req in the next cycle, with stc_tag equal to rej_tag. stc_status is 3'b100 for completer abort and 3'b001 for unsupported request. All three hold steady, and rej_ready stays low, until stc_ack is seen.
- R7: For a non-posted reject, err_pulse[2] (completer abort) or err_pulse[5] (unsupported request) appears exactly in the cycle after the one in which stc_req and stc_ack are both high, and never earlier.
- R8: Expired entries are reported one per cycle, lowest tag first, so entries expiring together yield pulses on consecutive cycles.
- R9: Events of different kinds that fall in the same cycle appear together in one err_pulse vector.
- R10: err_pulse[6] is always zero, and each reported event sets its bit for exactly one cycle.
- R11: Issuing a tag that is already live restarts its timeout from the new issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| np_issue | input | 2**TAG_W | One bit per tag: a non-posted request was issued on that tag |
| np_issue_corr | input | 2**TAG_W | Per tag: a timeout of that request is recoverable |
| cpl_in_valid | input | 1 | A completion was received |
| cpl_in_tag | input | TAG_W | Tag of the received completion |
| rej_valid | input | 1 | Reject decision offered |
| rej_posted | input | 1 | Rejected request was posted |
| rej_unsup | input | 1 | 1: unsupported request, 0: completer abort |
| rej_tag | input | TAG_W | Tag of the rejected non-posted request |
| rej_ready | output | 1 | Reject decisions are accepted this cycle |
| stc_req | output | 1 | Status completion requested |
| stc_tag | output | TAG_W | Tag for the status completion |
| stc_status | output | 3 | Completion status code |
| stc_ack | input | 1 | Transmit side took the status completion |
| err_pulse | output | 7 | One-cycle error event vector |

## Verification
The assertions watch the acknowledge ordering on every cycle. A non-posted reject bit may only follow a handshake, a held request may not change before it is acknowledged, a completion missing the table must give the unexpected bit, and the two timeout bits may never fire together. Timeout timing, the recoverable/non-recoverable choice, restart on reissue and the lowest-tag-first draining of simultaneous expiries depend on long histories of issues and completions. Only the bench's scenarios show these, through a cycle model of the requirements under directed and random traffic.

// File: rtl/cpl_err_tracker.sv
module cpl_err_tracker #(
  parameter int TAG_W       = 3,
  parameter int TIMEOUT_CYC = 12_500_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<TAG_W)-1:0]   np_issue,
  input  logic [(1<<TAG_W)-1:0]   np_issue_corr,
  input  logic                    cpl_in_valid,
  input  logic [TAG_W-1:0]        cpl_in_tag,
  input  logic                    rej_valid,
  input  logic                    rej_posted,
  input  logic                    rej_unsup,
  input  logic [TAG_W-1:0]        rej_tag,
  output logic                    rej_ready,
  output logic                    stc_req,
  output logic [TAG_W-1:0]        stc_tag,
  output logic [2:0]              stc_status,
  input  logic                    stc_ack,
  output logic [6:0]              err_pulse
);
  localparam int NT = 1 << TAG_W;
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

  logic [NT-1:0]    vld, corr, exp_q, exp_corr;
  logic [CW-1:0]    cnt [NT];
  logic             pend, pend_ur;
  logic [TAG_W-1:0] pend_tag, rep_idx;
  logic             rep_any, ack, acc;
  logic [6:0]       err_nxt;

  assign ack        = pend && stc_ack;
  assign acc        = rej_valid && !pend;
  assign rej_ready  = !pend;
  assign stc_req    = pend;
  assign stc_tag    = pend_tag;
  assign stc_status = pend_ur ? 3'b001 : 3'b100;
  assign rep_any    = |exp_q;

  always_comb begin
    rep_idx = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (exp_q[i]) rep_idx = TAG_W'(i);
  end

  for (genvar g = 0; g < NT; g++) begin : g_ent
    logic hit, expire;
    assign hit    = cpl_in_valid && (cpl_in_tag == TAG_W'(g));
    assign expire = vld[g] && !hit && (cnt[g] == LIM);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]      <= 1'b0;
        corr[g]     <= 1'b0;
        cnt[g]      <= '0;
        exp_q[g]    <= 1'b0;
        exp_corr[g] <= 1'b0;
      end else begin
        if (np_issue[g]) begin
          vld[g]  <= 1'b1;
          corr[g] <= np_issue_corr[g];
          cnt[g]  <= '0;
        end else if (vld[g]) begin
          if (hit || expire) vld[g] <= 1'b0;
          else               cnt[g] <= cnt[g] + 1'b1;
        end
        exp_q[g] <= expire | (exp_q[g] & ~(rep_any && rep_idx == TAG_W'(g)));
        if (expire) exp_corr[g] <= corr[g];
      end
    end
  end

  always_comb begin
    err_nxt    = '0;
    err_nxt[0] = rep_any && exp_corr[rep_idx];
    err_nxt[1] = rep_any && !exp_corr[rep_idx];
    err_nxt[2] = (ack && !pend_ur) || (acc && rej_posted && !rej_unsup);
    err_nxt[3] = cpl_in_valid && !vld[cpl_in_tag];
    err_nxt[4] = acc && rej_posted && rej_unsup;
    err_nxt[5] = ack && pend_ur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= '0;
      pend      <= 1'b0;
      pend_ur   <= 1'b0;
      pend_tag  <= '0;
    end else begin
      err_pulse <= err_nxt;
      if (ack) begin
        pend <= 1'b0;
      end else if (acc && !rej_posted) begin
        pend     <= 1'b1;
        pend_ur  <= rej_unsup;
        pend_tag <= rej_tag;
      end
    end
  end
endmodule

module cpl_err_tracker_chk #(
  parameter int TAG_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [6:0]            err_pulse,
  input logic                  stc_req,
  input logic                  stc_ack,
  input logic [TAG_W-1:0]      stc_tag,
  input logic [2:0]            stc_status,
  input logic                  cpl_in_valid,
  input logic [TAG_W-1:0]      cpl_in_tag,
  input logic [(1<<TAG_W)-1:0] vld
);
  assert_one_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse[0] && err_pulse[1]));

  assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stc_req && !stc_ack |=> stc_req && $stable(stc_tag) && $stable(stc_status));

  assert_ca_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stc_req && stc_ack && stc_status == 3'b100 |=> err_pulse[2]);

  assert_ur_only_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[5] |-> $past(stc_req && stc_ack && stc_status == 3'b001));

  assert_unexpected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_in_valid && !vld[cpl_in_tag] |=> err_pulse[3]);

  assert_no_false_unexp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[3] |-> $past(cpl_in_valid && !vld[cpl_in_tag]));
endmodule

bind cpl_err_tracker cpl_err_tracker_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .stc_req(stc_req),
  .stc_ack(stc_ack), .stc_tag(stc_tag), .stc_status(stc_status),
  .cpl_in_valid(cpl_in_valid), .cpl_in_tag(cpl_in_tag), .vld(vld)
);

// File: tb/cpl_err_tracker_tb_top.sv
module cpl_err_tracker_tb_top;
  localparam int T = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] np_issue = '0, np_issue_corr = '0;
  logic cpl_in_valid = 1'b0, rej_valid = 1'b0, rej_posted = 1'b0, rej_unsup = 1'b0, stc_ack = 1'b0;
  logic [2:0] cpl_in_tag = '0, rej_tag = '0, stc_tag, stc_status;
  logic rej_ready, stc_req;
  logic [6:0] err_pulse;

  always #10 clk = ~clk;

  cpl_err_tracker #(.TAG_W(3), .TIMEOUT_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .np_issue(np_issue), .np_issue_corr(np_issue_corr),
    .cpl_in_valid(cpl_in_valid), .cpl_in_tag(cpl_in_tag), .rej_valid(rej_valid),
    .rej_posted(rej_posted), .rej_unsup(rej_unsup), .rej_tag(rej_tag),
    .rej_ready(rej_ready), .stc_req(stc_req), .stc_tag(stc_tag),
    .stc_status(stc_status), .stc_ack(stc_ack), .err_pulse(err_pulse));

  int n_chk = 0, n_fail = 0, wd = 0;

  logic [7:0] m_vld, m_corr, m_exp, m_expc;
  int         m_dead [8];
  logic       m_pend, m_ur;
  logic [2:0] m_tag;
  logic [6:0] e_err;
  int         cyc;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at step %0d", req, act, expv, cyc);
    end
  endtask

  function automatic logic [2:0] status_of(input logic ur);
    return ur ? 3'b001 : 3'b100;
  endfunction

  task automatic model_reset();
    m_vld = '0; m_corr = '0; m_exp = '0; m_expc = '0;
    m_pend = 1'b0; m_ur = 1'b0; m_tag = '0; e_err = '0; cyc = 0;
    for (int t = 0; t < 8; t++) m_dead[t] = 0;
  endtask

  task automatic compare();
    check("R2 bit0", int'(err_pulse[0]), int'(e_err[0]));
    check("R2/R8 bit1", int'(err_pulse[1]), int'(e_err[1]));
    check("R5/R7 bit2", int'(err_pulse[2]), int'(e_err[2]));
    check("R4 bit3", int'(err_pulse[3]), int'(e_err[3]));
    check("R5 bit4", int'(err_pulse[4]), int'(e_err[4]));
    check("R7 bit5", int'(err_pulse[5]), int'(e_err[5]));
    check("R10 bit6", int'(err_pulse[6]), 0);
    check("R6 stc_req", int'(stc_req), int'(m_pend));
    check("R6 rej_ready", int'(rej_ready), int'(!m_pend));
    if (m_pend) begin
      check("R6 stc_tag", int'(stc_tag), int'(m_tag));
      check("R6 stc_status", int'(stc_status), int'(status_of(m_ur)));
    end
  endtask

  task automatic step(input logic [7:0] im, input logic [7:0] ic, input logic cv,
                      input logic [2:0] ct, input logic rv, input logic rp,
                      input logic ru, input logic [2:0] rt, input logic ak);
    logic [7:0] newexp;
    np_issue = im; np_issue_corr = ic; cpl_in_valid = cv; cpl_in_tag = ct;
    rej_valid = rv; rej_posted = rp; rej_unsup = ru; rej_tag = rt; stc_ack = ak;
    e_err = '0;
    newexp = '0;
    for (int t = 0; t < 8; t++)
      if (m_exp[t]) begin
        e_err[m_expc[t] ? 0 : 1] = 1'b1;
        m_exp[t] = 1'b0;
        break;
      end
    if (cv && !m_vld[ct]) e_err[3] = 1'b1;
    for (int t = 0; t < 8; t++) begin
      if (m_vld[t]) begin
        if (cv && ct == 3'(t)) m_vld[t] = 1'b0;
        else if (m_dead[t] == cyc) begin
          newexp[t] = 1'b1; m_expc[t] = m_corr[t]; m_vld[t] = 1'b0;
        end
      end
      if (im[t]) begin
        m_vld[t] = 1'b1; m_corr[t] = ic[t]; m_dead[t] = cyc + T;
      end
    end
    m_exp |= newexp;
    if (m_pend) begin
      if (ak) begin
        e_err[m_ur ? 5 : 2] = 1'b1;
        m_pend = 1'b0;
      end
    end else if (rv) begin
      if (rp) e_err[ru ? 4 : 2] = 1'b1;
      else begin m_pend = 1'b1; m_ur = ru; m_tag = rt; end
    end
    cyc++;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 0, '0, 0, 0, 0, '0, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 err_pulse", int'(err_pulse), 0);
    check("R1 stc_req", int'(stc_req), 0);
    check("R1 rej_ready", int'(rej_ready), 1);
    rst_n = 1'b1;

    // R8: tags 2 (recoverable) and 5 (not) expire together, tag 2 first
    step(8'h24, 8'h04, 0, '0, 0, 0, 0, '0, 0);
    idle(T + 4);
    // R3: completion frees the entry, no timeout later
    step(8'h02, 8'h02, 0, '0, 0, 0, 0, '0, 0);
    idle(5);
    step('0, '0, 1, 3'd1, 0, 0, 0, '0, 0);
    idle(T + 3);
    // R3: completion on the would-be expiry edge wins
    step(8'h08, 8'h00, 0, '0, 0, 0, 0, '0, 0);
    idle(T - 1);
    step('0, '0, 1, 3'd3, 0, 0, 0, '0, 0);
    idle(4);
    // R4: unexpected completion
    step('0, '0, 1, 3'd6, 0, 0, 0, '0, 0);
    // R5: posted completer abort and unsupported request
    step('0, '0, 0, '0, 1, 1, 0, '0, 0);
    step('0, '0, 0, '0, 1, 1, 1, '0, 0);
    // R6, R7: non-posted completer abort with late ack, then unsupported with prompt ack
    step('0, '0, 0, '0, 1, 0, 0, 3'd3, 0);
    step('0, '0, 0, '0, 1, 1, 1, '0, 0);
    idle(3);
    step('0, '0, 0, '0, 0, 0, 0, '0, 1);
    step('0, '0, 0, '0, 1, 0, 1, 3'd7, 0);
    step('0, '0, 0, '0, 0, 0, 0, '0, 1);
    idle(2);
    // R9: timeout report merged with an unexpected completion and a posted reject
    step(8'h01, 8'h00, 0, '0, 0, 0, 0, '0, 0);
    idle(T);
    step('0, '0, 1, 3'd4, 1, 1, 1, '0, 0);
    idle(2);
    // R11: reissue restarts the timer
    step(8'h04, 8'h04, 0, '0, 0, 0, 0, '0, 0);
    idle(10);
    step(8'h04, 8'h00, 0, '0, 0, 0, 0, '0, 0);
    idle(T + 3);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] im, ic;
      logic cv, rv, rp, ru, ak;
      logic [2:0] ct, rt;
      im = ($urandom % 4 == 0) ? 8'($urandom & $urandom & $urandom) : 8'h00;
      ic = 8'($urandom);
      cv = ($urandom % 3 == 0);
      ct = 3'($urandom);
      im[ct] = im[ct] & !cv;
      rv = ($urandom % 6 == 0);
      rp = $urandom % 2;
      ru = $urandom % 2;
      rt = 3'($urandom);
      ak = ($urandom % 3 == 0);
      step(im, ic, cv, ct, rv, rp, ru, rt, ak);
    end
    idle(T + 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule